// File: doc/BRIEF.md
# Accumulator Instruction Execute Unit

This block executes already decoded instructions for a single-accumulator, single-address machine with a 32-bit data word (sign in the top bit) and a 12-bit address space. Each accepted instruction brings an opcode, an effective address, the sign bit of the instruction word and two operator inputs: a transfer switch and four breakpoint switches. The unit owns the accumulator, the program counter and a sticky overflow flag. It drives a synchronous memory port whose read data returns one cycle after the request.

The control is a four-state machine:

- `ST_IDLE` accepts an instruction. Single-cycle instructions retire here, and reads are issued from here.
- `ST_FETCH` consumes the read data. Arithmetic and load instructions retire here; read-modify-write instructions capture the merged word.
- `ST_WBACK` writes the merged word back and retires.
- `ST_STOPPED` is entered from `ST_IDLE` by a stop instruction that no selected switch overrides. It is left only by reset.

Transitions:

- `ST_IDLE`→`ST_FETCH` on a read-type instruction.
- `ST_IDLE`→`ST_STOPPED` on a halting stop.
- `ST_FETCH`→`ST_WBACK` for read-modify-write instructions.
- `ST_FETCH`→`ST_IDLE` otherwise.
- `ST_WBACK`→`ST_IDLE` always.

Opcodes (4-bit `issue_op`):

| Code | Instruction |
|------|-------------|
| 0 | no-op |
| 1 | load |
| 2 | store |
| 3 | store-then-clear |
| 4 | address-field store |
| 5 | return-address store |
| 6 | jump |
| 7 | conditional jump |
| 8 | add |
| 9 | subtract |
| 10 | AND-extract |
| 11 | stop |
| 12–15 | no-op (multiply, divide and character I/O slots) |

The address field of a data word is bits [13:2].

Top module: `acc_exec_unit`

## Requirements
- R1: After reset, `acc`, `pc` and `ovf` are zero and `busy`, `halted` and `mem_req` are low.
- R2: Load (1), add (8), subtract (9) and extract (10) issue one read at `issue_addr` in the accept cycle and hold `busy` high for exactly one cycle. They then place, respectively, the memory word, the sum, the difference, or the bitwise AND with the accumulator into `acc`.
- R3: Add sets `ovf` when both operands share a sign and the sum's sign differs. Subtract sets `ovf` when the operands differ in sign and the result's sign differs from the accumulator's.
- R4: `ovf` is sticky. It falls only on reset or in the cycle after `ovf_clr` is high.
- R5: Store (2) writes `acc` to `issue_addr` in the accept cycle without going busy. Store-then-clear (3) does the same and then sets `acc` to zero.
- R6: Address-field store (4) reads the word at `issue_addr`, replaces bits [13:2] with `acc[13:2]`, and writes the result back to the same address. All other bits of the word are kept.
- R7: Return-address store (5) does the same as R6, but the field is replaced with (`pc`+1) modulo 4096, where `pc` is the value when the instruction was issued.
- R8: Read-modify-write instructions keep `busy` high for two cycles: a cycle with no memory request, then a write cycle with `mem_req` and `mem_we` high.
- R9: Jump (6) loads `pc` with `issue_addr`.
- R10: Conditional jump (7) loads `pc` with `issue_addr` when `acc[31]` is set, or when both `issue_sign` and `xfer_sw` are high. Otherwise `pc` advances by one.
- R11: Every non-transfer instruction advances `pc` by one on retirement, wrapping from 4095 to 0.
- R12: For stop (11), `issue_addr` bits 11, 10, 9 and 8 select `bp_sw[3]`, `bp_sw[2]`, `bp_sw[1]` and `bp_sw[0]`. If any selected switch is on, the instruction acts as a no-op. Otherwise `pc` advances and `halted` rises and stays high until reset, and further issues change no state.
- R13: Opcodes 0 and 12–15 only advance `pc`. An instruction offered while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| issue_op | input | 4 | Opcode |
| issue_addr | input | 12 | Effective address |
| issue_sign | input | 1 | Sign bit of the instruction word |
| xfer_sw | input | 1 | Transfer switch |
| bp_sw | input | 4 | Breakpoint switches (bit 3 is the highest-weight switch) |
| ovf_clr | input | 1 | Clears the overflow flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| acc | output | 32 | Accumulator |
| pc | output | 12 | Program counter |
| ovf | output | 1 | Sticky overflow flag |
| busy | output | 1 | Multi-cycle instruction in progress |
| halted | output | 1 | Stopped by a stop instruction |

## Verification
The bench builds the unit with its defaults: a 32-bit word, a 12-bit address and the address field at bit 2. With these values, a jump to 4095 followed by one sequential instruction reaches the PC wrap point, and loading 0x7FFFFFFF or 0x80000000 reaches both overflow boundaries of the sign bit. The four switch-select bits line up with the top of the 12-bit address, so every switch/select pairing of the stop instruction is reachable.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_LOAD  = 4'd1,
        OP_STORE = 4'd2,
        OP_CLRST = 4'd3,
        OP_STADR = 4'd4,
        OP_STRET = 4'd5,
        OP_JUMP  = 4'd6,
        OP_JNEG  = 4'd7,
        OP_ADD   = 4'd8,
        OP_SUB   = 4'd9,
        OP_AND   = 4'd10,
        OP_HALT  = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WBACK,
        ST_STOPPED
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_AND
    } alu_e;

    function automatic logic op_reads(op_e o);
        return (o == OP_LOAD) || (o == OP_ADD) || (o == OP_SUB) ||
               (o == OP_AND) || (o == OP_STADR) || (o == OP_STRET);
    endfunction

    function automatic logic op_rmw(op_e o);
        return (o == OP_STADR) || (o == OP_STRET);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_exec_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_e          sel,
    output logic [DW-1:0] y,
    output logic          ovf
);
    always_comb begin
        y   = b;
        ovf = 1'b0;
        unique case (sel)
            ALU_PASS: y = b;
            ALU_ADD: begin
                y   = a + b;
                ovf = (a[DW-1] == b[DW-1]) && (y[DW-1] != a[DW-1]);
            end
            ALU_SUB: begin
                y   = a - b;
                ovf = (a[DW-1] != b[DW-1]) && (y[DW-1] != a[DW-1]);
            end
            ALU_AND: y = a & b;
        endcase
    end
endmodule

// File: rtl/acc_flow.sv
module acc_flow
    import acc_exec_pkg::*;
#(
    parameter int AW  = 12,
    parameter int NSW = 4
) (
    input  op_e           op,
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] pc,
    input  logic          acc_neg,
    input  logic          isign,
    input  logic          xfer_sw,
    input  logic [NSW-1:0] bp_sw,
    output logic [AW-1:0] pc_next,
    output logic          halt_req
);
    localparam int SEL_LSB = AW - NSW;

    logic [NSW-1:0] hit;
    logic [AW-1:0]  pc_seq;
    logic           taken;

    for (genvar i = 0; i < NSW; i++) begin : g_sw
        assign hit[i] = ea[SEL_LSB+i] & bp_sw[i];
    end

    assign pc_seq = pc + AW'(1);

    always_comb begin
        taken = 1'b0;
        if (op == OP_JUMP) taken = 1'b1;
        else if (op == OP_JNEG) taken = acc_neg | (isign & xfer_sw);
    end

    assign pc_next  = taken ? ea : pc_seq;
    assign halt_req = (op == OP_HALT) && !(|hit);
endmodule

// File: rtl/acc_merge.sv
module acc_merge #(
    parameter int DW      = 32,
    parameter int AW      = 12,
    parameter int FLD_LSB = 2
) (
    input  logic [DW-1:0] word,
    input  logic [AW-1:0] fld,
    output logic [DW-1:0] y
);
    localparam logic [DW-1:0] FMASK = {{(DW-AW){1'b0}}, {AW{1'b1}}} << FLD_LSB;

    logic [DW-1:0] fld_w;
    assign fld_w = {{(DW-AW){1'b0}}, fld} << FLD_LSB;
    assign y     = (word & ~FMASK) | fld_w;
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_exec_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 12,
    parameter int FLD_LSB = 2,
    parameter int NSW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_valid,
    input  logic [3:0]    issue_op,
    input  logic [AW-1:0] issue_addr,
    input  logic          issue_sign,
    input  logic          xfer_sw,
    input  logic [NSW-1:0] bp_sw,
    input  logic          ovf_clr,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          ovf,
    output logic          busy,
    output logic          halted
);
    state_e        state_q, state_d;
    op_e           op_q, cur_op;
    logic [AW-1:0] ea_q, cur_ea;
    logic [DW-1:0] acc_q, wbuf_q;
    logic [AW-1:0] pc_q, pc_next, pc_ret, merge_fld;
    logic          ovf_q, ovf_set, halt_req, accept;
    alu_e          alu_sel;
    logic [DW-1:0] alu_y, merged;
    logic          alu_ovf;

    assign accept = issue_valid && (state_q == ST_IDLE);
    assign cur_op = (state_q == ST_IDLE) ? op_e'(issue_op) : op_q;
    assign cur_ea = (state_q == ST_IDLE) ? issue_addr : ea_q;
    assign pc_ret = pc_q + AW'(1);

    always_comb begin
        unique case (op_q)
            OP_ADD:  alu_sel = ALU_ADD;
            OP_SUB:  alu_sel = ALU_SUB;
            OP_AND:  alu_sel = ALU_AND;
            default: alu_sel = ALU_PASS;
        endcase
    end

    assign merge_fld = (op_q == OP_STRET) ? pc_ret : acc_q[FLD_LSB +: AW];
    assign ovf_set   = (state_q == ST_FETCH) && !op_rmw(op_q) && alu_ovf;

    acc_alu #(.DW(DW)) alu_i (
        .a(acc_q), .b(mem_rdata), .sel(alu_sel), .y(alu_y), .ovf(alu_ovf)
    );

    acc_flow #(.AW(AW), .NSW(NSW)) flow_i (
        .op(cur_op), .ea(cur_ea), .pc(pc_q), .acc_neg(acc_q[DW-1]),
        .isign(issue_sign), .xfer_sw(xfer_sw), .bp_sw(bp_sw),
        .pc_next(pc_next), .halt_req(halt_req)
    );

    acc_merge #(.DW(DW), .AW(AW), .FLD_LSB(FLD_LSB)) merge_i (
        .word(mem_rdata), .fld(merge_fld), .y(merged)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (op_reads(cur_op))  state_d = ST_FETCH;
                    else if (halt_req)     state_d = ST_STOPPED;
                end
            end
            ST_FETCH:   state_d = op_rmw(op_q) ? ST_WBACK : ST_IDLE;
            ST_WBACK:   state_d = ST_IDLE;
            ST_STOPPED: state_d = ST_STOPPED;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_ea;
        mem_wdata = acc_q;
        busy      = 1'b0;
        halted    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (op_reads(cur_op)) begin
                        mem_req = 1'b1;
                    end else if (cur_op == OP_STORE || cur_op == OP_CLRST) begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                    end
                end
            end
            ST_FETCH: busy = 1'b1;
            ST_WBACK: begin
                busy      = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wbuf_q;
            end
            ST_STOPPED: halted = 1'b1;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            pc_q   <= '0;
            ovf_q  <= 1'b0;
            op_q   <= OP_NOP;
            ea_q   <= '0;
            wbuf_q <= '0;
        end else begin
            ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q <= cur_op;
                        ea_q <= issue_addr;
                        if (!op_reads(cur_op)) pc_q <= pc_next;
                        if (cur_op == OP_CLRST) acc_q <= '0;
                    end
                end
                ST_FETCH: begin
                    if (op_rmw(op_q)) begin
                        wbuf_q <= merged;
                    end else begin
                        acc_q <= alu_y;
                        pc_q  <= pc_next;
                    end
                end
                ST_WBACK:   pc_q <= pc_next;
                ST_STOPPED: ;
            endcase
        end
    end

    assign acc = acc_q;
    assign pc  = pc_q;
    assign ovf = ovf_q;
endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk
    import acc_exec_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 12,
    parameter int NSW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          issue_valid,
    input logic [3:0]    issue_op,
    input logic [AW-1:0] issue_addr,
    input logic          ovf_clr,
    input logic          mem_req,
    input logic          mem_we,
    input logic [DW-1:0] acc,
    input logic [AW-1:0] pc,
    input logic          ovf,
    input logic          busy,
    input logic          halted
);
    logic          acc_ok;
    logic [AW-1:0] pc_inc;

    assign acc_ok = issue_valid && !busy && !halted;

    always_ff @(posedge clk) pc_inc <= pc + AW'(1);

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && issue_op == OP_CLRST) |=> (acc == '0));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !busy && !mem_req));

    assert_rmw_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && (issue_op == OP_STADR || issue_op == OP_STRET))
            |-> ##2 (mem_req && mem_we && busy));

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && issue_op == OP_JUMP) |=> (pc == $past(issue_addr)));

    assert_seq_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && issue_op == OP_STORE) |=> (pc == pc_inc));
endmodule

bind acc_exec_unit acc_exec_chk #(.DW(DW), .AW(AW), .NSW(NSW)) chk_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_addr(issue_addr), .ovf_clr(ovf_clr), .mem_req(mem_req),
    .mem_we(mem_we), .acc(acc), .pc(pc), .ovf(ovf), .busy(busy),
    .halted(halted)
);

// File: tb/acc_exec_unit_tb_top.sv
`timescale 1ns/1ps
module acc_exec_unit_tb_top;
    localparam int DW = 32;
    localparam int AW = 12;
    localparam logic [31:0] FM = 32'h0000_3FFC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [3:0]    issue_op = '0;
    logic [AW-1:0] issue_addr = '0;
    logic          issue_sign = 1'b0;
    logic          xfer_sw = 1'b0;
    logic [3:0]    bp_sw = '0;
    logic          ovf_clr = 1'b0;
    logic          mem_req, mem_we, ovf, busy, halted;
    logic [AW-1:0] mem_addr, pc;
    logic [DW-1:0] mem_wdata, acc;
    logic [DW-1:0] mem_rdata = '0;

    logic [31:0] mem [0:63];
    logic [31:0] m_mem [0:63];
    logic [31:0] m_acc;
    logic [11:0] m_pc;
    logic        m_ovf, m_halt;
    int n_chk = 0, n_bad = 0;
    bit ended = 0;

    always #2.5 clk = ~clk;

    acc_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
        .issue_addr(issue_addr), .issue_sign(issue_sign), .xfer_sw(xfer_sw),
        .bp_sw(bp_sw), .ovf_clr(ovf_clr), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc(acc), .pc(pc), .ovf(ovf), .busy(busy), .halted(halted)
    );

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[5:0]];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic logic add_ovf(logic [31:0] a, logic [31:0] b);
        longint s = longint'($signed(a)) + longint'($signed(b));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    function automatic logic sub_ovf(logic [31:0] a, logic [31:0] b);
        longint s = longint'($signed(a)) - longint'($signed(b));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic model_step(input logic [3:0] op, input logic [11:0] ea,
                              input logic sg, input logic xs, input logic [3:0] bps);
        logic [5:0]  ix = ea[5:0];
        logic [11:0] nxt = m_pc + 12'd1;
        if (m_halt) return;
        case (op)
            4'd1: m_acc = m_mem[ix];
            4'd2: m_mem[ix] = m_acc;
            4'd3: begin m_mem[ix] = m_acc; m_acc = 0; end
            4'd4: m_mem[ix] = (m_mem[ix] & ~FM) | (m_acc & FM);
            4'd5: m_mem[ix] = (m_mem[ix] & ~FM) | ({20'd0, nxt} << 2);
            4'd6: nxt = ea;
            4'd7: if (m_acc[31] || (sg && xs)) nxt = ea;
            4'd8: begin if (add_ovf(m_acc, m_mem[ix])) m_ovf = 1; m_acc = m_acc + m_mem[ix]; end
            4'd9: begin if (sub_ovf(m_acc, m_mem[ix])) m_ovf = 1; m_acc = m_acc - m_mem[ix]; end
            4'd10: m_acc = m_acc & m_mem[ix];
            4'd11: if ((ea[11:8] & bps) == 4'd0) m_halt = 1;
            default: ;
        endcase
        m_pc = nxt;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_acc = 0; m_pc = 0; m_ovf = 0; m_halt = 0;
    endtask

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd1, 4'd8, 4'd10: return "R2";
            4'd9: return "R3";
            4'd2, 4'd3: return "R5";
            4'd4: return "R6";
            4'd5: return "R7";
            4'd6: return "R9";
            4'd7: return "R10";
            4'd11: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic exec(input logic [3:0] op, input logic [11:0] ea,
                        input logic sg, input logic xs, input logic [3:0] bps);
        string t = tag_of(op);
        model_step(op, ea, sg, xs, bps);
        @(negedge clk);
        issue_valid = 1; issue_op = op; issue_addr = ea;
        issue_sign = sg; xfer_sw = xs; bp_sw = bps;
        @(negedge clk);
        issue_valid = 0;
        while (busy) @(negedge clk);
        chk({t, " acc"}, acc, m_acc);
        chk({t, " pc R11"}, {20'd0, pc}, {20'd0, m_pc});
        chk({t, " ovf R3 R4"}, {31'd0, ovf}, {31'd0, m_ovf});
        chk({t, " halted"}, {31'd0, halted}, {31'd0, m_halt});
        chk({t, " mem"}, mem[ea[5:0]], m_mem[ea[5:0]]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) begin
            mem[i] = $urandom; m_mem[i] = mem[i];
        end
        mem[1] = 32'h7FFF_FFFF; m_mem[1] = mem[1];
        mem[2] = 32'h0000_0001; m_mem[2] = mem[2];
        mem[3] = 32'h8000_0000; m_mem[3] = mem[3];
        do_reset();
        // R1 reset state
        chk("R1 acc", acc, 0);
        chk("R1 pc", {20'd0, pc}, 0);
        chk("R1 flags", {28'd0, ovf, busy, halted, mem_req}, 0);

        // R2 / R3 overflow on add, then R4 sticky and clear
        exec(4'd1, 12'h001, 0, 0, 0);
        exec(4'd8, 12'h002, 0, 0, 0);
        exec(4'd10, 12'h002, 0, 0, 0);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        m_ovf = 0;
        chk("R4 clear", {31'd0, ovf}, 0);
        exec(4'd1, 12'h003, 0, 0, 0);
        exec(4'd9, 12'h002, 0, 0, 0);

        // R8 read-modify-write timing
        model_step(4'd4, 12'h005, 0, 0, 0);
        @(negedge clk); issue_valid = 1; issue_op = 4'd4; issue_addr = 12'h005;
        @(negedge clk); issue_valid = 0;
        chk("R8 cycle1", {29'd0, busy, mem_req, mem_we}, 32'b100);
        @(negedge clk);
        chk("R8 cycle2", {29'd0, busy, mem_req, mem_we}, 32'b111);
        @(negedge clk);
        chk("R8 done", {31'd0, busy}, 0);
        chk("R6 merge", mem[5], m_mem[5]);

        // R13 ignored while busy
        model_step(4'd8, 12'h006, 0, 0, 0);
        @(negedge clk); issue_valid = 1; issue_op = 4'd8; issue_addr = 12'h006;
        @(negedge clk); issue_op = 4'd6; issue_addr = 12'h123;
        @(negedge clk); issue_valid = 0;
        chk("R13 busy ignore pc", {20'd0, pc}, {20'd0, m_pc});
        exec(4'd13, 12'h010, 0, 0, 0);

        // R11 wrap, R7 at wrap
        exec(4'd6, 12'hFFF, 0, 0, 0);
        exec(4'd5, 12'h007, 0, 0, 0);
        exec(4'd6, 12'hFFF, 0, 0, 0);
        exec(4'd2, 12'h008, 0, 0, 0);
        exec(4'd3, 12'h009, 0, 0, 0);

        // R10 conditional cases (acc is zero here)
        exec(4'd7, 12'h0A0, 1, 0, 0);
        exec(4'd7, 12'h0B0, 1, 1, 0);
        exec(4'd7, 12'h0C0, 0, 1, 0);
        exec(4'd1, 12'h003, 0, 0, 0);
        exec(4'd7, 12'h0D0, 0, 0, 0);

        // R12 breakpoint switches
        exec(4'd11, 12'h800, 0, 0, 4'b1000);
        exec(4'd11, 12'h100, 0, 0, 4'b0001);
        exec(4'd11, 12'h400, 0, 0, 4'b1000);
        exec(4'd6, 12'h222, 0, 0, 0);
        do_reset();

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] op = 4'($urandom_range(0, 15));
            logic [11:0] ea = 12'($urandom);
            exec(op, ea, 1'($urandom), 1'($urandom), 4'($urandom));
            if (m_halt) do_reset();
        end
        finish_run();
    end
endmodule